// File: doc/BRIEF.md
# Receive DMA descriptor writer

This block sits at the end of a multichannel HDLC receive DMA path. Each time a data buffer has been filled, the block receives a completion event. The event carries the channel number, the number of bytes stored, an end-of-frame flag, the buffer's start address, the address of the descriptor slot and the offset of the next descriptor. For every accepted event the block writes one receive descriptor to memory as three 32-bit words on a valid/ready write port. The fourth word of the descriptor slot is left for the host.

The block tracks, for each of its 40 channels, whether a packet is still open. From that state it tags each buffer as the first, a middle or the last buffer of a packet. A free-running timestamp counts the clock divided by 16, and its value is stamped into the third word when that word is first offered. Events with a channel outside 1 to 40, or with a byte count above 8191, are refused with a one-cycle error pulse and produce no writes.

Top module: `rxdesc_writer`

## Requirements
- R1: While reset is asserted, evt_ready is 1, wr_valid is 0 and evt_err is 0. The timestamp restarts at 0 when reset is released.
- R2: Each accepted valid event produces exactly three writes, in this order: desc_addr+0, desc_addr+4, desc_addr+8. No write to desc_addr+12 or any other address follows.
- R3: The word at offset 0 equals the buffer start address of the event.
- R4: Word 1 bits 31:29 hold the buffer status. The code 100 is used when the event ends the frame. Otherwise the code is 001 if no packet is open on that channel, and 010 if one is open. An end of frame closes the channel's packet, and a non-final buffer opens it.
- R5: Word 1 bits 28:16 hold the event's byte count (0 to 8191).
- R6: Word 1 bits 15:0 hold the next-descriptor offset when the status is 001 or 010, and 0 when the status is 100.
- R7: Word 2 bits 5:0 hold the channel number minus one (channel 1 gives 0x00, channel 40 gives 0x27). Bits 7:6 are 0.
- R8: Word 2 bits 31:8 hold floor(n/16) mod 2^24, where n is the number of rising clock edges since reset release, taken in the first cycle word 2 is offered. The value is held while the write is stalled.
- R9: While wr_valid is high and wr_ready is low, wr_addr and wr_data stay stable. evt_ready is high only when no descriptor is being written.
- R10: An event with channel 0 or above 40, or with a byte count above 8191 (evt_bytes is 14 bits wide), raises evt_err for exactly the one cycle after the handshake. It produces no writes and leaves every channel's packet state unchanged.
- R11: The first word is offered in the cycle after the event handshake. evt_ready returns in the cycle after the last word's handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| evt_valid | input | 1 | Completion event present |
| evt_ready | output | 1 | Block can take an event |
| evt_chan | input | 6 | Channel number, 1 to 40 |
| evt_bytes | input | 14 | Bytes stored in the buffer |
| evt_eof | input | 1 | Buffer ends the packet |
| evt_buf_addr | input | 32 | Start address of the data buffer |
| evt_desc_addr | input | 32 | Byte address of the descriptor slot |
| evt_next_off | input | 16 | Offset of the next descriptor from the descriptor base |
| wr_valid | output | 1 | Write word present |
| wr_ready | input | 1 | Memory side takes the word |
| wr_addr | output | 32 | Byte address of the word |
| wr_data | output | 32 | Descriptor word |
| evt_err | output | 1 | Rejected-event pulse |

## Verification
The bench first sends a single-buffer packet on every channel from 1 to 40. Byte counts include 0 and 8191, and three write-stall patterns are used, so channel encoding, field placement and the zeroed next offset are each separated from their neighbours. Multi-buffer packets are then sent on one channel, and interleaved on two channels. These show whether the first/middle/last sequencing is kept per channel or shared. Out-of-range channels and byte counts are also sent, including one on a channel with an open packet, which shows whether rejection leaves that packet's state alone. Timestamps are compared with an edge count kept by the bench, both after short gaps and after a long idle period.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_W0   = 2'd1,
    ST_W1   = 2'd2,
    ST_W2   = 2'd3
  } wr_state_e;

  localparam logic [2:0] BS_FIRST = 3'b001;
  localparam logic [2:0] BS_MID   = 3'b010;
  localparam logic [2:0] BS_LAST  = 3'b100;
endpackage

// File: rtl/rxd_tstamp.sv
module rxd_tstamp #(
  parameter int PRE_W = 4,
  parameter int TS_W  = 24
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [TS_W-1:0] ts
);
  logic [PRE_W-1:0] pre_q, pre_d;
  logic [TS_W-1:0]  ts_q, ts_d;
  logic             pre_wrap;

  always_comb begin
    pre_wrap = (pre_q == {PRE_W{1'b1}});
    pre_d    = pre_q + 1'b1;
    ts_d     = pre_wrap ? ts_q + 1'b1 : ts_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      ts_q  <= '0;
    end else begin
      pre_q <= pre_d;
      ts_q  <= ts_d;
    end
  end

  assign ts = ts_q;

  AST_TS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (ts_q == $past(ts_q)) || (ts_q == $past(ts_q) + 1'b1)); // R8
endmodule

// File: rtl/rxd_chan_track.sv
module rxd_chan_track
  import rxd_pkg::*;
#(
  parameter int NCHAN = 40,
  parameter int CH_W  = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            upd,
  input  logic [CH_W-1:0] idx,
  input  logic            eof,
  output logic [2:0]      status
);
  logic [NCHAN-1:0] open_q, open_d;
  logic             open_bit;

  always_comb begin
    open_bit = 1'b0;
    if (int'(idx) < NCHAN) open_bit = open_q[idx];
    if (eof)           status = BS_LAST;
    else if (open_bit) status = BS_MID;
    else               status = BS_FIRST;
  end

  for (genvar i = 0; i < NCHAN; i++) begin : g_flag
    always_comb begin
      open_d[i] = open_q[i];
      if (upd && (idx == CH_W'(i))) open_d[i] = !eof;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) open_q <= '0;
    else        open_q <= open_d;
  end

  AST_FLAG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> open_q == $past(open_q)); // R10
endmodule

// File: rtl/rxd_word_out.sv
module rxd_word_out
  import rxd_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int TS_W   = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] base_in,
  input  logic [31:0]       w0_in,
  input  logic [31:0]       w1_in,
  input  logic [7:0]        w2_lo_in,
  input  logic [TS_W-1:0]   ts,
  input  logic              wr_ready,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [31:0]       wr_data,
  output logic [1:0]        word_sel,
  output logic              idle
);
  wr_state_e         st_q, st_d;
  logic [ADDR_W-1:0] base_q;
  logic [31:0]       w0_q, w1_q;
  logic [7:0]        lo_q;
  logic [TS_W-1:0]   hold_q, hold_d;
  logic              frz_q, frz_d;
  logic [TS_W-1:0]   ts_word;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE: if (load)     st_d = ST_W0;
      ST_W0:   if (wr_ready) st_d = ST_W1;
      ST_W1:   if (wr_ready) st_d = ST_W2;
      ST_W2:   if (wr_ready) st_d = ST_IDLE;
      default:               st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    frz_d  = 1'b0;
    hold_d = hold_q;
    if (st_q == ST_W2 && !wr_ready) frz_d = 1'b1;
    if (st_q == ST_W2 && !frz_q)    hold_d = ts;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      frz_q  <= 1'b0;
      hold_q <= '0;
      base_q <= '0;
      w0_q   <= '0;
      w1_q   <= '0;
      lo_q   <= '0;
    end else begin
      st_q   <= st_d;
      frz_q  <= frz_d;
      hold_q <= hold_d;
      if (load && st_q == ST_IDLE) begin
        base_q <= base_in;
        w0_q   <= w0_in;
        w1_q   <= w1_in;
        lo_q   <= w2_lo_in;
      end
    end
  end

  always_comb begin
    ts_word  = frz_q ? hold_q : ts;
    idle     = (st_q == ST_IDLE);
    wr_valid = !idle;
    word_sel = 2'd0;
    wr_data  = w0_q;
    case (st_q)
      ST_W1: begin word_sel = 2'd1; wr_data = w1_q; end
      ST_W2: begin word_sel = 2'd2; wr_data = {ts_word, lo_q}; end
      default: begin word_sel = 2'd0; wr_data = w0_q; end
    endcase
    wr_addr = base_q + ADDR_W'({word_sel, 2'b00});
  end

  AST_WORD_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_ready && word_sel != 2'd2 |=> wr_valid && word_sel == $past(word_sel) + 2'd1); // R2
  AST_LAST_WORD_END: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_ready && word_sel == 2'd2 |=> !wr_valid && idle); // R11
endmodule

// File: rtl/rxdesc_writer.sv
module rxdesc_writer
  import rxd_pkg::*;
#(
  parameter int NCHAN  = 40,
  parameter int CH_W   = 6,
  parameter int BC_W   = 13,
  parameter int OFF_W  = 16,
  parameter int ADDR_W = 32,
  parameter int TS_W   = 24,
  parameter int PRE_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_valid,
  output logic              evt_ready,
  input  logic [CH_W-1:0]   evt_chan,
  input  logic [BC_W:0]     evt_bytes,
  input  logic              evt_eof,
  input  logic [ADDR_W-1:0] evt_buf_addr,
  input  logic [ADDR_W-1:0] evt_desc_addr,
  input  logic [OFF_W-1:0]  evt_next_off,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [31:0]       wr_data,
  output logic              evt_err
);
  localparam int LO_PAD = 8 - CH_W;

  logic            accept, fields_ok, load, idle;
  logic [CH_W-1:0] idx;
  logic [2:0]      status;
  logic [OFF_W-1:0] next_eff;
  logic [31:0]     w0, w1;
  logic [7:0]      w2_lo;
  logic [TS_W-1:0] ts;
  logic [1:0]      word_sel;
  logic            err_q, err_d;

  always_comb begin
    accept    = evt_valid && evt_ready;
    fields_ok = (evt_chan != '0) && (int'(evt_chan) <= NCHAN) && !evt_bytes[BC_W];
    load      = accept && fields_ok;
    err_d     = accept && !fields_ok;
    idx       = evt_chan - 1'b1;
    next_eff  = evt_eof ? '0 : evt_next_off;
    w0        = 32'(evt_buf_addr);
    w1        = {status, evt_bytes[BC_W-1:0], next_eff};
    w2_lo     = {{LO_PAD{1'b0}}, idx};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end

  rxd_tstamp #(.PRE_W(PRE_W), .TS_W(TS_W)) u_ts (
    .clk(clk), .rst_n(rst_n), .ts(ts)
  );

  rxd_chan_track #(.NCHAN(NCHAN), .CH_W(CH_W)) u_trk (
    .clk(clk), .rst_n(rst_n), .upd(load), .idx(idx), .eof(evt_eof), .status(status)
  );

  rxd_word_out #(.ADDR_W(ADDR_W), .TS_W(TS_W)) u_out (
    .clk(clk), .rst_n(rst_n), .load(load), .base_in(evt_desc_addr),
    .w0_in(w0), .w1_in(w1), .w2_lo_in(w2_lo), .ts(ts), .wr_ready(wr_ready),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .word_sel(word_sel), .idle(idle)
  );

  assign evt_ready = idle;
  assign evt_err   = err_q;

  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data)); // R9
  AST_BUSY_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> !evt_ready); // R9
  AST_STATUS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && word_sel == 2'd1 |-> $onehot(wr_data[31:29])); // R4
  AST_LAST_NO_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && word_sel == 2'd1 && wr_data[31] |-> wr_data[15:0] == '0); // R6
  AST_CHAN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && word_sel == 2'd2 |-> wr_data[7:6] == 2'b00 && int'(wr_data[5:0]) < NCHAN); // R7
  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    evt_err |-> !wr_valid && evt_ready); // R10
  AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    evt_err |=> !evt_err); // R10
  AST_FIRST_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> wr_valid && word_sel == 2'd0); // R11
endmodule

// File: tb/rxdesc_writer_tb_top.sv
module rxdesc_writer_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        evt_valid, evt_ready, evt_eof, evt_err;
  logic [5:0]  evt_chan;
  logic [13:0] evt_bytes;
  logic [31:0] evt_buf_addr, evt_desc_addr;
  logic [15:0] evt_next_off;
  logic        wr_valid, wr_ready;
  logic [31:0] wr_addr, wr_data;

  int checks = 0;
  int errors = 0;
  int ecnt = 0;
  bit done = 0;
  bit open_m [1:40];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) if (rst_n) ecnt <= ecnt + 1;

  rxdesc_writer dut_i (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_ready(evt_ready),
    .evt_chan(evt_chan), .evt_bytes(evt_bytes), .evt_eof(evt_eof),
    .evt_buf_addr(evt_buf_addr), .evt_desc_addr(evt_desc_addr),
    .evt_next_off(evt_next_off), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .evt_err(evt_err)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input int ch, input int bc, input bit eof, input logic [31:0] a,
                      input logic [31:0] base, input logic [15:0] nxt, input int stall);
    bit ok;
    logic [2:0] st;
    logic [31:0] exp_w [3];
    logic [31:0] tsx, p_addr, p_data;
    bit seen2, was_stall;
    int w, cyc;
    ok = (ch >= 1) && (ch <= 40) && (bc <= 8191);
    @(negedge clk);
    chk(evt_ready == 1'b1, "R9 idle ready", 32'(evt_ready), 1);
    evt_valid = 1; evt_chan = 6'(ch); evt_bytes = 14'(bc); evt_eof = eof;
    evt_buf_addr = a; evt_desc_addr = base; evt_next_off = nxt;
    @(posedge clk);
    @(negedge clk);
    evt_valid = 0;
    if (!ok) begin
      chk(evt_err == 1'b1, "R10 err pulse", 32'(evt_err), 1);
      chk(wr_valid == 1'b0, "R10 no write", 32'(wr_valid), 0);
      wr_ready = 1;
      for (int k = 0; k < 4; k++) begin
        @(negedge clk);
        chk(evt_err == 1'b0 && wr_valid == 1'b0, "R10 quiet after",
            {30'b0, evt_err, wr_valid}, 0);
      end
      wr_ready = 0;
      return;
    end
    st = eof ? 3'b100 : (open_m[ch] ? 3'b010 : 3'b001);
    open_m[ch] = !eof;
    exp_w[0] = a;
    exp_w[1] = {st, 13'(bc), eof ? 16'h0 : nxt};
    chk(wr_valid == 1'b1 && wr_addr == base, "R11 first word next cycle", wr_addr, base);
    w = 0; cyc = 0; seen2 = 0; was_stall = 0; tsx = 0; p_addr = 0; p_data = 0;
    while (w < 3 && cyc < 60) begin
      if (was_stall)
        chk(wr_valid && wr_addr == p_addr && wr_data == p_data, "R9 hold", wr_data, p_data);
      if (wr_valid && wr_addr == base + 8 && !seen2) begin
        seen2 = 1;
        tsx = 32'((ecnt / 16) % (1 << 24));
        exp_w[2] = {tsx[23:0], 2'b00, 6'(ch - 1)};
      end
      case (stall)
        0: wr_ready = 1;
        1: wr_ready = (cyc % 2 == 1);
        default: wr_ready = (cyc % 3 == 2);
      endcase
      chk(evt_ready == 1'b0, "R9 busy", 32'(evt_ready), 0);
      if (wr_valid && wr_ready) begin
        chk(wr_addr == base + 32'(4 * w), "R2 address order", wr_addr, base + 32'(4 * w));
        case (w)
          0: chk(wr_data == exp_w[0], "R3 word0", wr_data, exp_w[0]);
          1: begin
            chk(wr_data[31:29] == exp_w[1][31:29], "R4 status", 32'(wr_data[31:29]), 32'(exp_w[1][31:29]));
            chk(wr_data[28:16] == exp_w[1][28:16], "R5 bytes", 32'(wr_data[28:16]), 32'(exp_w[1][28:16]));
            chk(wr_data[15:0] == exp_w[1][15:0], "R6 next off", 32'(wr_data[15:0]), 32'(exp_w[1][15:0]));
          end
          default: begin
            chk(wr_data[7:0] == exp_w[2][7:0], "R7 chan field", 32'(wr_data[7:0]), 32'(exp_w[2][7:0]));
            chk(wr_data[31:8] == exp_w[2][31:8], "R8 timestamp", 32'(wr_data[31:8]), 32'(exp_w[2][31:8]));
          end
        endcase
        w++;
        was_stall = 0;
      end else begin
        was_stall = wr_valid;
        p_addr = wr_addr; p_data = wr_data;
      end
      cyc++;
      @(negedge clk);
    end
    chk(w == 3, "R2 three writes", 32'(w), 3);
    chk(evt_ready == 1'b1 && wr_valid == 1'b0, "R11 ready after last",
        {30'b0, evt_ready, wr_valid}, 32'b10);
    wr_ready = 1;
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      chk(wr_valid == 1'b0, "R2 no fourth write", wr_addr, 0);
    end
    wr_ready = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; evt_valid = 0; evt_chan = 0; evt_bytes = 0; evt_eof = 0;
    evt_buf_addr = 0; evt_desc_addr = 0; evt_next_off = 0; wr_ready = 0;
    for (int c = 1; c <= 40; c++) open_m[c] = 0;
    repeat (3) @(negedge clk);
    chk(evt_ready == 1'b1, "R1 reset ready", 32'(evt_ready), 1);
    chk(wr_valid == 1'b0, "R1 reset wr_valid", 32'(wr_valid), 0);
    chk(evt_err == 1'b0, "R1 reset err", 32'(evt_err), 0);
    rst_n = 1;
    // R4 single-buffer on every channel, with byte count corners for R5
    for (int c = 1; c <= 40; c++)
      send(c, (c == 1) ? 0 : (c == 40) ? 8191 : c * 197, 1, 32'h1000_0000 + 32'(c) * 32'h100,
           32'h0002_0000 + 32'(c) * 16, 16'(c * 3), c % 3);
    // R4 multi-buffer on one channel
    send(7, 100, 0, 32'hA000_0000, 32'h0003_0000, 16'h0010, 0);
    send(7, 200, 0, 32'hA000_1000, 32'h0003_0010, 16'h0020, 1);
    send(7, 300, 0, 32'hA000_2000, 32'h0003_0020, 16'h0030, 2);
    send(7, 400, 1, 32'hA000_3000, 32'h0003_0030, 16'h0040, 0);
    // R4 interleaved channels
    send(3, 10, 0, 32'hB000_0000, 32'h0004_0000, 16'h1111, 1);
    send(40, 20, 0, 32'hB100_0000, 32'h0004_0010, 16'h2222, 0);
    send(3, 30, 0, 32'hB000_1000, 32'h0004_0020, 16'h3333, 2);
    send(40, 40, 1, 32'hB100_1000, 32'h0004_0030, 16'h4444, 0);
    send(3, 50, 1, 32'hB000_2000, 32'h0004_0040, 16'h5555, 1);
    send(40, 60, 1, 32'hB100_2000, 32'h0004_0050, 16'h6666, 2);
    // R10 rejected events
    send(0, 5, 1, 32'hC000_0000, 32'h0005_0000, 16'h0001, 0);
    send(41, 5, 1, 32'hC000_0000, 32'h0005_0000, 16'h0001, 0);
    send(63, 5, 0, 32'hC000_0000, 32'h0005_0000, 16'h0001, 0);
    send(5, 8192, 1, 32'hC000_0000, 32'h0005_0000, 16'h0001, 0);
    send(9, 0, 0, 32'hC100_0000, 32'h0005_0010, 16'h0002, 0);
    send(9, 16383, 1, 32'hC100_1000, 32'h0005_0020, 16'h0003, 0);
    send(9, 8192, 0, 32'hC100_1000, 32'h0005_0020, 16'h0003, 0);
    send(9, 8191, 0, 32'hC100_2000, 32'h0005_0030, 16'h0004, 1);
    send(9, 1, 1, 32'hC100_3000, 32'h0005_0040, 16'h0005, 2);
    // R8 timestamp after a long idle gap
    repeat (2000) @(negedge clk);
    send(12, 77, 1, 32'hD000_0000, 32'h0006_0000, 16'h0006, 2);
    repeat (37) @(negedge clk);
    send(12, 78, 0, 32'hD000_1000, 32'h0006_0010, 16'h0007, 1);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule